// File: doc/BRIEF.md
# Dual Wiper SPI Register Slave

This block is the digital control front end of a two-channel, 128-step digitally controlled resistor. An external host drives an SPI mode-0 bus (chip select, serial clock and serial data in). Each transaction is a 16-bit frame. The first byte is a command: a 3-bit opcode in its top bits and a 5-bit register address below it. The second byte is write data, or the slot in which read data is shifted out. The block holds two 7-bit wiper codes and a one-bit shutdown control, and it drives the effective wiper codes and a shutdown flag as parallel outputs to the resistor array.

The bus pins are brought into the system clock domain through synchronizers, and the bus clock edges are found by edge detection. The serial clock therefore has to be several times slower than the system clock. A write takes effect only when a frame is complete. While shutdown is active, the wiper outputs show a fixed end-of-range code but the stored codes are kept. They reappear on the outputs when shutdown is released.

Top module: `dcr_spi_slave`

## Requirements
- R1: After reset both stored wiper codes are 0x40, shutdown is inactive (control bit 6 = 1), and `sdo_o` is 0.
- R2: Frames are shifted MSB first, with SDI sampled on rising SCK. Command 110 with address 00000 writes bits 6:0 of the data byte to wiper 0. Bit 7 of the data byte is dropped.
- R3: Command 110 with address 00001 writes wiper 1 and leaves wiper 0 unchanged.
- R4: Command 100 with address 00000 or 00001 returns the selected wiper code, with bit 7 = 0, in the data slot. Each bit is changed on falling SCK and is valid at the next rising SCK.
- R5: Command 011 writes data bit 6 into the shutdown control bit, and command 001 reads it back as bit 6 of a byte whose other bits are 0. The address field is ignored for both commands.
- R6: Commands 100 and 110 with address 10000 read and write the shutdown control bit in the same way as commands 001 and 011.
- R7: While the control bit is 0, `shdn_o` is 1 and every wiper output shows code 0. The stored codes are unchanged, and they return to the outputs when the bit is set back to 1.
- R8: Opcode 000, any opcode not listed above, and commands 100 and 110 with an address outside {00000, 00001, 10000} change no register and put 0 on SDO. Write commands also put 0 on SDO.
- R9: If CS rises before all 16 bits have arrived, no register is changed, and the next frame starts from bit 0.
- R10: SDO is 0 while CS is high and during the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI serial clock from the host |
| cs_n_i | input | 1 | SPI chip select, active low |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial read data to the host |
| wipers_o | output | NUM_WIPERS*WIPER_W | Effective wiper codes, wiper 0 in the low bits |
| shdn_o | output | 1 | Shutdown flag, active high |

## Verification
The bench uses the default build: two 7-bit wipers, mid-scale 0x40, shutdown code 0 and two synchronizer stages. With these values, address 00001 is the last wiper, address 00010 is an unmapped address, and the shutdown code is different from the reset code, so a missing shutdown override shows up at the outputs. Each SCK phase lasts eight system clocks. This leaves room for the synchronizer and edge-detect latency before the host samples SDO, so read data is checked at the same rising edge a real host would use. The bench mixes random commands and addresses, including unlisted ones, with frames cut short at random bit counts.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 3;
  localparam int ADDR_W = BYTE_W - OP_W;

  localparam logic [OP_W-1:0] OP_NOP    = 3'b000;
  localparam logic [OP_W-1:0] OP_CTL_RD = 3'b001;
  localparam logic [OP_W-1:0] OP_CTL_WR = 3'b011;
  localparam logic [OP_W-1:0] OP_SEL_RD = 3'b100;
  localparam logic [OP_W-1:0] OP_SEL_WR = 3'b110;

  localparam logic [ADDR_W-1:0] CTL_ADDR = 5'b10000;
endpackage

// File: rtl/dcr_pin_sync.sv
module dcr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic sdi_i,
  output logic rst_n_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic sdi_s
);
  logic [1:0]        rst_ff;
  logic [STAGES-1:0] sck_ff, sck_ff_d;
  logic [STAGES-1:0] cs_ff,  cs_ff_d;
  logic [STAGES-1:0] sdi_ff, sdi_ff_d;
  logic              sck_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_n_s = rst_ff[1];

  always_comb begin
    sck_ff_d = {sck_ff[STAGES-2:0], sck_i};
    cs_ff_d  = {cs_ff[STAGES-2:0],  cs_n_i};
    sdi_ff_d = {sdi_ff[STAGES-2:0], sdi_i};
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sck_ff   <= '0;
      cs_ff    <= '1;
      sdi_ff   <= '0;
      sck_last <= 1'b0;
    end else begin
      sck_ff   <= sck_ff_d;
      cs_ff    <= cs_ff_d;
      sdi_ff   <= sdi_ff_d;
      sck_last <= sck_ff[STAGES-1];
    end
  end

  assign sck_rise = sck_ff[STAGES-1] & ~sck_last;
  assign sck_fall = ~sck_ff[STAGES-1] & sck_last;
  assign cs_act   = ~cs_ff[STAGES-1];
  assign sdi_s    = sdi_ff[STAGES-1];
endmodule

// File: rtl/dcr_spi_shifter.sv
module dcr_spi_shifter
  import dcr_pkg::*;
#(
  parameter int FRAME_BITS = 2 * BYTE_W,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi_s,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] instr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              commit,
  output logic              sdo,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] rx_q, rx_d, rx_next;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] instr_q, instr_d;
  logic              sdo_q, sdo_d;
  logic              load_q, load_d;
  logic              commit_q, commit_d;

  always_comb begin
    cnt_d    = cnt_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    instr_d  = instr_q;
    sdo_d    = sdo_q;
    load_d   = 1'b0;
    commit_d = 1'b0;
    rx_next  = {rx_q[BYTE_W-2:0], sdi_s};
    if (!cs_act) begin
      cnt_d = '0;
      tx_d  = '0;
      sdo_d = 1'b0;
    end else begin
      if (sck_rise && (cnt_q < CNT_W'(FRAME_BITS))) begin
        rx_d  = rx_next;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(BYTE_W - 1)) begin
          instr_d = rx_next;
          load_d  = 1'b1;
        end
        if (cnt_q == CNT_W'(FRAME_BITS - 1)) commit_d = 1'b1;
      end
      if (load_q) begin
        tx_d = rd_data;
      end else if (sck_fall) begin
        sdo_d = tx_q[BYTE_W-1];
        tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      instr_q  <= '0;
      sdo_q    <= 1'b0;
      load_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      instr_q  <= instr_d;
      sdo_q    <= sdo_d;
      load_q   <= load_d;
      commit_q <= commit_d;
    end
  end

  assign instr   = instr_q;
  assign wr_data = rx_q;
  assign commit  = commit_q;
  assign sdo     = sdo_q;
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/dcr_reg_bank.sv
module dcr_reg_bank
  import dcr_pkg::*;
#(
  parameter int NUM_WIPERS = 2,
  parameter int WIPER_W    = 7,
  parameter int MID_CODE   = 64,
  parameter int SHDN_BIT   = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [BYTE_W-1:0]             instr,
  input  logic                          commit,
  input  logic [BYTE_W-1:0]             wr_data,
  output logic [BYTE_W-1:0]             rd_data,
  output logic [NUM_WIPERS*WIPER_W-1:0] store_flat,
  output logic                          run_q
);
  logic [OP_W-1:0]       op;
  logic [ADDR_W-1:0]     addr;
  logic [NUM_WIPERS-1:0] hit_w;
  logic                  hit_ctl, is_rd, is_wr, run_d;
  logic [WIPER_W-1:0]    wip_q [NUM_WIPERS];

  assign op   = instr[BYTE_W-1 -: OP_W];
  assign addr = instr[ADDR_W-1:0];

  always_comb begin
    hit_w   = '0;
    hit_ctl = 1'b0;
    is_rd   = 1'b0;
    is_wr   = 1'b0;
    case (op)
      OP_CTL_RD: begin hit_ctl = 1'b1; is_rd = 1'b1; end
      OP_CTL_WR: begin hit_ctl = 1'b1; is_wr = 1'b1; end
      OP_SEL_RD, OP_SEL_WR: begin
        is_rd = (op == OP_SEL_RD);
        is_wr = (op == OP_SEL_WR);
        if (addr == CTL_ADDR) hit_ctl = 1'b1;
        for (int k = 0; k < NUM_WIPERS; k++)
          if (addr == ADDR_W'(k)) hit_w[k] = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    rd_data = '0;
    if (is_rd) begin
      if (hit_ctl) rd_data[SHDN_BIT] = run_q;
      for (int k = 0; k < NUM_WIPERS; k++)
        if (hit_w[k]) rd_data = BYTE_W'(wip_q[k]);
    end
  end

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_wiper
    logic [WIPER_W-1:0] wip_d;
    always_comb begin
      wip_d = wip_q[g];
      if (commit && is_wr && hit_w[g]) wip_d = wr_data[WIPER_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wip_q[g] <= WIPER_W'(MID_CODE);
      else        wip_q[g] <= wip_d;
    end
    assign store_flat[g*WIPER_W +: WIPER_W] = wip_q[g];
  end

  always_comb begin
    run_d = run_q;
    if (commit && is_wr && hit_ctl) run_d = wr_data[SHDN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b1;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/dcr_spi_slave.sv
module dcr_spi_slave
  import dcr_pkg::*;
#(
  parameter int NUM_WIPERS  = 2,
  parameter int WIPER_W     = 7,
  parameter int MID_CODE    = 64,
  parameter int SHDN_CODE   = 0,
  parameter int SHDN_BIT    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sck_i,
  input  logic                          cs_n_i,
  input  logic                          sdi_i,
  output logic                          sdo_o,
  output logic [NUM_WIPERS*WIPER_W-1:0] wipers_o,
  output logic                          shdn_o
);
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic                          rst_n_s, sck_rise, sck_fall, cs_act, sdi_s;
  logic [BYTE_W-1:0]             instr, wr_data, rd_data;
  logic                          commit, run_q;
  logic [CNT_W-1:0]              bit_cnt;
  logic [NUM_WIPERS*WIPER_W-1:0] store_flat;

  dcr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .cs_n_i(cs_n_i), .sdi_i(sdi_i),
    .rst_n_s(rst_n_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_act(cs_act), .sdi_s(sdi_s)
  );

  dcr_spi_shifter #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .cs_act(cs_act), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .sdi_s(sdi_s), .rd_data(rd_data), .instr(instr),
    .wr_data(wr_data), .commit(commit), .sdo(sdo_o), .bit_cnt(bit_cnt)
  );

  dcr_reg_bank #(
    .NUM_WIPERS(NUM_WIPERS), .WIPER_W(WIPER_W),
    .MID_CODE(MID_CODE), .SHDN_BIT(SHDN_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s), .instr(instr), .commit(commit),
    .wr_data(wr_data), .rd_data(rd_data), .store_flat(store_flat), .run_q(run_q)
  );

  assign shdn_o = ~run_q;

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_out
    assign wipers_o[g*WIPER_W +: WIPER_W] =
      shdn_o ? WIPER_W'(SHDN_CODE) : store_flat[g*WIPER_W +: WIPER_W];
  end
endmodule

// File: rtl/dcr_spi_slave_chk.sv
module dcr_spi_slave_chk #(
  parameter int STORE_W    = 14,
  parameter int CNT_W      = 5,
  parameter int FRAME_BITS = 16
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic               cs_act,
  input logic               sdo_o,
  input logic               commit,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic [STORE_W-1:0] store_flat,
  input logic [STORE_W-1:0] wipers_o,
  input logic               shdn_o
);
  assert_sdo_idle_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cs_act |=> !sdo_o);

  assert_store_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !commit |=> $stable(store_flat));

  assert_commit_full_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    commit |-> bit_cnt == CNT_W'(FRAME_BITS));

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    bit_cnt <= CNT_W'(FRAME_BITS));

  assert_shdn_keep_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(shdn_o) |-> $stable(store_flat));

  assert_shdn_restore_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(shdn_o) |-> wipers_o == store_flat);
endmodule

bind dcr_spi_slave dcr_spi_slave_chk #(
  .STORE_W(NUM_WIPERS*WIPER_W), .CNT_W(CNT_W), .FRAME_BITS(FRAME_BITS)
) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .cs_act(cs_act), .sdo_o(sdo_o),
  .commit(commit), .bit_cnt(bit_cnt), .store_flat(store_flat),
  .wipers_o(wipers_o), .shdn_o(shdn_o)
);

// File: tb/dcr_spi_slave_bench.sv
module dcr_spi_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, shdn;
  logic [13:0] wipers;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [6:0] m_w0 = 7'h40, m_w1 = 7'h40;
  logic       m_run = 1'b1;

  always #10 clk = ~clk;

  dcr_spi_slave u_dcr_spi_slave (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .sdi_i(sdi),
    .sdo_o(sdo), .wipers_o(wipers), .shdn_o(shdn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] ins);
    logic [4:0] a = ins[4:0];
    case (ins[7:5])
      3'b001: return {1'b0, m_run, 6'b0};
      3'b100: begin
        if (a == 5'd0)  return {1'b0, m_w0};
        if (a == 5'd1)  return {1'b0, m_w1};
        if (a == 5'd16) return {1'b0, m_run, 6'b0};
        return 8'h00;
      end
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] ins, input logic [7:0] d);
    logic [4:0] a = ins[4:0];
    case (ins[7:5])
      3'b011: m_run = d[6];
      3'b110: begin
        if (a == 5'd0) m_w0 = d[6:0];
        else if (a == 5'd1) m_w1 = d[6:0];
        else if (a == 5'd16) m_run = d[6];
      end
      default: ;
    endcase
  endtask

  task automatic xfer(input logic [7:0] ins, input logic [7:0] d, input int nbits,
                      output logic [7:0] rd, output logic cmd_zero);
    logic [15:0] fr = {ins, d};
    rd = 8'h00;
    cmd_zero = 1'b1;
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = fr[15-i];
      repeat (8) @(negedge clk);
      if (i < 8) begin
        if (sdo !== 1'b0) cmd_zero = 1'b0;
      end else begin
        rd[15-i] = sdo;
      end
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic chk_outs(input string req);
    chk(req, {18'b0, wipers}, m_run ? {18'b0, m_w1, m_w0} : 32'h0);
    chk(req, {31'b0, shdn}, {31'b0, ~m_run});
  endtask

  task automatic frame(input string req, input logic [7:0] ins, input logic [7:0] d);
    logic [7:0] rd;
    logic z;
    logic [7:0] e = exp_rd(ins);
    xfer(ins, d, 16, rd, z);
    chk({req, " sdo zero in command byte R10"}, {31'b0, z}, 32'd1);
    chk({req, " read slot"}, {24'b0, rd}, {24'b0, e});
    model_wr(ins, d);
    chk_outs({req, " outputs"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic z;
    int seed_use;
    seed_use = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    chk("R1 reset wipers", {18'b0, wipers}, 32'h0000_2040);
    chk("R1 reset shdn", {31'b0, shdn}, 32'd0);
    chk("R10 sdo idle", {31'b0, sdo}, 32'd0);
    frame("R1 reset readback", 8'b100_00000, 8'h00);

    frame("R2 write wiper0 bit7 dropped", 8'b110_00000, 8'hFF);
    frame("R4 read wiper0", 8'b100_00000, 8'h00);
    frame("R3 write wiper1", 8'b110_00001, 8'h15);
    frame("R3 read wiper1", 8'b100_00001, 8'hAA);
    frame("R5 ctl write addr ignored", 8'b011_10101, 8'h00);
    frame("R5 ctl read addr ignored", 8'b001_00111, 8'h00);
    frame("R7 write in shutdown", 8'b110_00000, 8'h2A);
    frame("R6 ctl read by addr", 8'b100_10000, 8'h00);
    frame("R6 R7 ctl write by addr restore", 8'b110_10000, 8'h40);
    frame("R8 unlisted opcode", 8'b010_00000, 8'h11);
    frame("R8 unlisted opcode 111", 8'b111_00001, 8'h22);
    frame("R8 unmapped addr write", 8'b110_00010, 8'h33);
    frame("R8 unmapped addr read", 8'b100_00010, 8'h00);
    frame("R8 nop", 8'b000_00000, 8'h5A);

    xfer(8'b110_00000, 8'h01, 12, rd, z);
    chk_outs("R9 abort after 12 bits");
    xfer(8'b011_00000, 8'h00, 15, rd, z);
    chk_outs("R9 abort after 15 bits");
    frame("R9 frame after abort", 8'b100_00000, 8'h00);

    for (int n = 0; n < 200; n++) begin
      logic [7:0] ins;
      logic [4:0] a;
      logic [7:0] d = 8'($urandom);
      case ($urandom % 4)
        0: a = 5'd0;
        1: a = 5'd1;
        2: a = 5'd16;
        default: a = 5'($urandom);
      endcase
      case ($urandom % 8)
        0: ins = {3'b000, a};
        1: ins = {3'b001, a};
        2: ins = {3'b011, a};
        3, 4: ins = {3'b100, a};
        5, 6: ins = {3'b110, a};
        default: ins = 8'($urandom);
      endcase
      if ($urandom % 10 == 0) begin
        xfer(ins, d, 1 + int'($urandom % 15), rd, z);
        chk_outs("R9 random abort");
      end else begin
        frame("R4 R8 random frame", ins, d);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule